// File: doc/BRIEF.md
# Loop Sequencer with Address Post-Increment

This block sits beside an instruction fetch unit and runs a hardware loop with no branch or pointer-update instructions in the body. Software gives it the first and last addresses of the body, the index of a count register that ends the loop, and up to four address-stepping slots. When fetch presents the end address while the loop is armed, the block tells fetch to go back to the start address. If the count register already reads zero, it lets fetch fall through and disarms itself.

At each such boundary every valid slot produces a register write. The new value is the slot's address register plus the value of its length register scaled by a power of two, where the shift selects the element size (a shift of 2 gives 4-byte elements). The body usually rewrites the length register with a set-vector-length operation on every pass, so the step size can change from one iteration to the next. The block reads the register values that the register file presents and returns the new addresses on the normal write path. The redirect and the writes are combinational from the fetch PC in the boundary cycle. The armed state changes at the next clock edge.

Configuration uses one write port with a 4-bit select. Select 0 holds the start address and select 1 holds the end address. Select 2 is the control word: bits [3:0] hold the count register index and bit 8 arms the loop. Selects 4 to 7 configure slots 0 to 3. In a slot word, bits [3:0] hold the address register index, bits [7:4] hold the length register index, bits [10:8] hold the shift, and bit 12 is the valid bit.

Top module: `loop_seq`

## Requirements
- R1: After reset the loop is disarmed and all slots are invalid, so no redirect and no register update is produced even when fetch presents the reset end address of 0.
- R2: While armed, if fetch presents a valid PC equal to the end address and the selected count register is non-zero, `redir_valid` is 1 and `redir_pc` equals the start address in that same cycle.
- R3: While armed, if the count register is zero when the end address is presented, `redir_valid` stays 0 and the loop disarms at the next clock edge. Later boundaries produce neither redirects nor updates until the loop is armed again.
- R4: At a boundary each valid slot s raises `upd_valid[s]`, drives `upd_idx` slot s (bits [3s+2:3s]) with its address register index, and drives `upd_data` slot s (bits [32s+31:32s]) with address + length × 2^shift, for every shift from 0 to 7.
- R5: A slot whose valid bit is 0 never raises its `upd_valid` bit.
- R6: On the exit pass, where the count is zero, the valid slots still produce their updates.
- R7: Each update uses the length register value present in the boundary cycle, so different lengths on successive iterations give different steps.
- R8: A write to the start or the end address disarms the loop. The next boundary then gives no redirect and no update, until a control write with bit 8 set arms the loop again.
- R9: No redirect or update is produced when the fetch PC differs from the end address or when `fetch_valid` is 0.
- R10: The address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| fetch_valid | input | 1 | Fetch PC is valid this cycle |
| fetch_pc | input | 32 | Current fetch PC |
| reg_vals | input | 256 | Values of the 8 architectural registers, register i at bits [32i+31:32i] |
| redir_valid | output | 1 | Fetch must go to `redir_pc` |
| redir_pc | output | 32 | Loop start address |
| upd_valid | output | 4 | Per-slot register write enable |
| upd_idx | output | 12 | Per-slot destination register index, 3 bits per slot |
| upd_data | output | 128 | Per-slot incremented address, 32 bits per slot |

## Verification
On every cycle the assertions check four things. A redirect only happens while the loop is armed. Updates only appear when fetch is at the end address. An exit or an address write leaves the loop disarmed at the next edge. An armed loop stays armed when there is neither a boundary nor a configuration write. The exact stepped values, their change as the length varies between iterations, the full shift range, wraparound, and the updates on the exit pass can only be shown by the bench. It runs strip-mined loops against its own register model and computes each expected address arithmetically.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;
  localparam logic [3:0] SEL_START = 4'd0;
  localparam logic [3:0] SEL_END   = 4'd1;
  localparam logic [3:0] SEL_CTRL  = 4'd2;
  localparam logic [3:0] SEL_SLOT0 = 4'd4;
  localparam int         ARM_BIT   = 8;

  typedef struct packed {
    logic       vld;
    logic [2:0] shift;
    logic [3:0] len_idx;
    logic [3:0] reg_idx;
  } slot_cfg_t;

  function automatic slot_cfg_t unpack_slot(input logic [31:0] w);
    slot_cfg_t c;
    c.reg_idx = w[3:0];
    c.len_idx = w[7:4];
    c.shift   = w[10:8];
    c.vld     = w[12];
    return c;
  endfunction
endpackage

// File: rtl/loop_cfg_regs.sv
module loop_cfg_regs
  import loop_seq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NSLOT = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [3:0]             cfg_sel,
  input  logic [XLEN-1:0]        cfg_wdata,
  input  logic                   exit_evt,
  output logic [XLEN-1:0]        start_q,
  output logic [XLEN-1:0]        end_q,
  output logic [3:0]             cnt_idx_q,
  output logic                   active_q,
  output slot_cfg_t [NSLOT-1:0]  slots_q
);
  logic wr_bound, wr_ctrl;
  assign wr_bound = cfg_we && (cfg_sel == SEL_START || cfg_sel == SEL_END);
  assign wr_ctrl  = cfg_we && (cfg_sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= '0;
      end_q     <= '0;
      cnt_idx_q <= '0;
      active_q  <= 1'b0;
    end else begin
      if (cfg_we && cfg_sel == SEL_START) start_q <= cfg_wdata;
      if (cfg_we && cfg_sel == SEL_END)   end_q   <= cfg_wdata;
      if (wr_ctrl) begin
        cnt_idx_q <= cfg_wdata[3:0];
        active_q  <= cfg_wdata[ARM_BIT];
      end else if (wr_bound || exit_evt) begin
        active_q  <= 1'b0;
      end
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slots_q[s] <= '0;
      else if (cfg_we && cfg_sel == SEL_SLOT0 + 4'(s))
        slots_q[s] <= unpack_slot(cfg_wdata[31:0]);
    end
  end

  AST_CANCEL_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bound && !wr_ctrl) |=> !active_q); // R8
  AST_EXIT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_evt && !wr_ctrl) |=> !active_q); // R3
  AST_ARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !exit_evt && !cfg_we) |=> active_q); // R9
endmodule

// File: rtl/loop_boundary.sv
module loop_boundary #(
  parameter int XLEN = 32
) (
  input  logic            fetch_valid,
  input  logic [XLEN-1:0] fetch_pc,
  input  logic            active,
  input  logic [XLEN-1:0] start_addr,
  input  logic [XLEN-1:0] end_addr,
  input  logic [XLEN-1:0] cnt_val,
  output logic            hit,
  output logic            exit_evt,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc
);
  logic cnt_zero;
  assign cnt_zero    = (cnt_val == '0);
  assign hit         = active && fetch_valid && (fetch_pc == end_addr);
  assign exit_evt    = hit && cnt_zero;
  assign redir_valid = hit && !cnt_zero;
  assign redir_pc    = start_addr;
endmodule

// File: rtl/loop_incr_slot.sv
module loop_incr_slot
  import loop_seq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 8,
  localparam int IDXW = $clog2(NREGS)
) (
  input  logic                  hit,
  input  slot_cfg_t             cfg,
  input  logic [NREGS*XLEN-1:0] reg_vals,
  output logic                  upd_valid,
  output logic [IDXW-1:0]       upd_idx,
  output logic [XLEN-1:0]       upd_data
);
  function automatic logic [XLEN-1:0] step_addr(input logic [XLEN-1:0] base,
                                                input logic [XLEN-1:0] len,
                                                input logic [2:0]      shift);
    logic [XLEN-1:0] scale;
    scale = XLEN'(1) << shift;
    return base + len * scale;
  endfunction

  logic [IDXW-1:0] a_idx, l_idx;
  logic [XLEN-1:0] a_val, l_val;
  assign a_idx = cfg.reg_idx[IDXW-1:0];
  assign l_idx = cfg.len_idx[IDXW-1:0];
  assign a_val = reg_vals[a_idx*XLEN +: XLEN];
  assign l_val = reg_vals[l_idx*XLEN +: XLEN];

  assign upd_valid = hit && cfg.vld;
  assign upd_idx   = a_idx;
  assign upd_data  = step_addr(a_val, l_val, cfg.shift);
endmodule

// File: rtl/loop_seq.sv
module loop_seq
  import loop_seq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 8,
  parameter int NSLOT = 4,
  localparam int IDXW = $clog2(NREGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [3:0]             cfg_sel,
  input  logic [XLEN-1:0]        cfg_wdata,
  input  logic                   fetch_valid,
  input  logic [XLEN-1:0]        fetch_pc,
  input  logic [NREGS*XLEN-1:0]  reg_vals,
  output logic                   redir_valid,
  output logic [XLEN-1:0]        redir_pc,
  output logic [NSLOT-1:0]       upd_valid,
  output logic [NSLOT*IDXW-1:0]  upd_idx,
  output logic [NSLOT*XLEN-1:0]  upd_data
);
  logic [XLEN-1:0]       start_q, end_q, cnt_val;
  logic [3:0]            cnt_idx_q;
  logic                  active_q, hit, exit_evt;
  slot_cfg_t [NSLOT-1:0] slots_q;

  loop_cfg_regs #(.XLEN(XLEN), .NSLOT(NSLOT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .exit_evt(exit_evt), .start_q(start_q),
    .end_q(end_q), .cnt_idx_q(cnt_idx_q), .active_q(active_q), .slots_q(slots_q)
  );

  assign cnt_val = reg_vals[cnt_idx_q[IDXW-1:0]*XLEN +: XLEN];

  loop_boundary #(.XLEN(XLEN)) u_bnd (
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .active(active_q),
    .start_addr(start_q), .end_addr(end_q), .cnt_val(cnt_val),
    .hit(hit), .exit_evt(exit_evt), .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    loop_incr_slot #(.XLEN(XLEN), .NREGS(NREGS)) u_slot (
      .hit(hit), .cfg(slots_q[s]), .reg_vals(reg_vals),
      .upd_valid(upd_valid[s]), .upd_idx(upd_idx[s*IDXW +: IDXW]),
      .upd_data(upd_data[s*XLEN +: XLEN])
    );
  end

  AST_REDIR_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> active_q); // R2
  AST_UPD_AT_END_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid != '0) |-> (fetch_valid && fetch_pc == end_q)); // R9
  AST_NO_REDIR_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid) |-> (cnt_val != '0)); // R3
endmodule

// File: tb/tb_loop_seq.sv
module tb_loop_seq;
  localparam int XLEN = 32, NREGS = 8, NSLOT = 4, IDXW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic [NREGS*XLEN-1:0] reg_vals;
  logic redir_valid;
  logic [31:0] redir_pc;
  logic [NSLOT-1:0] upd_valid;
  logic [NSLOT*IDXW-1:0] upd_idx;
  logic [NSLOT*XLEN-1:0] upd_data;

  logic [31:0] rf [NREGS];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < NREGS; i++) reg_vals[i*XLEN +: XLEN] = rf[i];

  loop_seq dut (.*);

  localparam logic [31:0] START = 32'h0000_0100, ENDA = 32'h0000_0140;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] slot_word(input int r, input int l, input int sh, input bit v);
    return (32'(v) << 12) | (32'(sh) << 8) | (32'(l) << 4) | 32'(r);
  endfunction

  // present pc; returns after #1 in the low phase, before the next edge
  task automatic present(input bit v, input logic [31:0] pc);
    @(negedge clk);
    fetch_valid = v; fetch_pc = pc;
    #1;
  endtask

  task automatic expect_slot(input int s, input bit v, input int r, input logic [31:0] d, input string req);
    chk(upd_valid[s] == v, req, 32'(upd_valid[s]), 32'(v));
    if (v) begin
      chk(upd_idx[s*IDXW +: IDXW] == IDXW'(r), req, 32'(upd_idx[s*IDXW +: IDXW]), 32'(r));
      chk(upd_data[s*XLEN +: XLEN] == d, req, upd_data[s*XLEN +: XLEN], d);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int rem, vl, k;
    logic [31:0] e2, e3, e4;
    for (int i = 0; i < NREGS; i++) rf[i] = '0;
    #9 rst_n = 1'b1;

    // R1: reset state, end address is 0
    present(1'b1, 32'h0);
    chk(redir_valid == 1'b0, "R1 redirect", 32'(redir_valid), 0);
    chk(upd_valid == '0, "R1 updates", 32'(upd_valid), 0);
    present(1'b0, 32'h0);

    // configuration: count reg 1; slots: r2/len r5 x4, r3/len r5 x4, r4/len r6 x1, slot3 invalid
    cfg_wr(4'd0, START);
    cfg_wr(4'd1, ENDA);
    cfg_wr(4'd4, slot_word(2, 5, 2, 1'b1));
    cfg_wr(4'd5, slot_word(3, 5, 2, 1'b1));
    cfg_wr(4'd6, slot_word(4, 6, 0, 1'b1));
    cfg_wr(4'd7, slot_word(7, 5, 3, 1'b0));
    rf[2] = 32'h1000; rf[3] = 32'h2000; rf[4] = 32'h30;
    rem = 11;
    rf[1] = 32'(rem);
    cfg_wr(4'd2, 32'h100 | 32'd1);

    k = 0;
    while (1) begin
      vl = (rem > 4) ? 4 : rem;
      rem = rem - vl;
      rf[1] = 32'(rem); rf[5] = 32'(vl); rf[6] = 32'(k * 3 + 1);
      // R9: a PC inside the body does nothing
      present(1'b1, START + 32'h10);
      chk(redir_valid == 1'b0 && upd_valid == '0, "R9 mid-body pc", 32'(upd_valid), 0);
      // R9: end address without fetch_valid
      present(1'b0, ENDA);
      chk(redir_valid == 1'b0 && upd_valid == '0, "R9 fetch_valid low", 32'(upd_valid), 0);
      present(1'b1, ENDA);
      e2 = rf[2] + 32'(vl) * 4; e3 = rf[3] + 32'(vl) * 4; e4 = rf[4] + rf[6];
      if (rem != 0) begin
        chk(redir_valid == 1'b1, "R2 redirect", 32'(redir_valid), 1);
        chk(redir_pc == START, "R2 target", redir_pc, START);
      end else begin
        chk(redir_valid == 1'b0, "R3 exit no redirect", 32'(redir_valid), 0);
      end
      expect_slot(0, 1'b1, 2, e2, rem == 0 ? "R6 slot0" : "R7 slot0");
      expect_slot(1, 1'b1, 3, e3, rem == 0 ? "R6 slot1" : "R4 slot1");
      expect_slot(2, 1'b1, 4, e4, "R7 slot2");
      expect_slot(3, 1'b0, 7, 0, "R5 invalid slot");
      @(posedge clk); #1;
      rf[2] = e2; rf[3] = e3; rf[4] = e4;
      k++;
      if (rem == 0) break;
    end
    // R3: disarmed afterwards
    rf[1] = 32'd9;
    present(1'b1, ENDA);
    chk(redir_valid == 1'b0, "R3 stays off", 32'(redir_valid), 0);
    chk(upd_valid == '0, "R3 no updates", 32'(upd_valid), 0);

    // R4 and R10: shift sweep with wrap
    for (int sh = 0; sh < 8; sh++) begin
      for (int lv = 1; lv < 40; lv += 13) begin
        cfg_wr(4'd4, slot_word(2, 5, sh, 1'b1));
        cfg_wr(4'd2, 32'h100 | 32'd1);
        rf[1] = 32'd1; rf[5] = 32'(lv);
        rf[2] = 32'hFFFF_FFF0 - 32'(sh);
        present(1'b1, ENDA);
        e2 = rf[2] + 32'(lv) * (32'd1 << sh);
        expect_slot(0, 1'b1, 2, e2, (e2 < rf[2]) ? "R10 wrap" : "R4 shift");
        chk(redir_valid == 1'b1, "R2 sweep redirect", 32'(redir_valid), 1);
        present(1'b0, 32'h0);
      end
    end

    // R8: writing start cancels; then writing end cancels
    cfg_wr(4'd2, 32'h100 | 32'd1);
    rf[1] = 32'd3;
    cfg_wr(4'd0, START);
    present(1'b1, ENDA);
    chk(redir_valid == 1'b0 && upd_valid == '0, "R8 start write cancels", 32'(redir_valid), 0);
    cfg_wr(4'd2, 32'h100 | 32'd1);
    present(1'b1, ENDA);
    chk(redir_valid == 1'b1, "R8 rearm works", 32'(redir_valid), 1);
    present(1'b0, 32'h0);
    cfg_wr(4'd1, ENDA);
    present(1'b1, ENDA);
    chk(redir_valid == 1'b0 && upd_valid == '0, "R8 end write cancels", 32'(upd_valid), 0);
    present(1'b0, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule